// File: doc/BRIEF.md
# Reloadable Bit-Serial Distributed-Arithmetic FIR Filter

This block is an eight-tap FIR filter with no multipliers. Each accepted input sample enters a tap delay line. The filter then spends one cycle on each sample bit position, least significant bit first. In each of those cycles it takes that bit from every tap and uses the bits as addresses into partial-sum tables. Each table serves four taps and has sixteen entries. The table outputs are added together, and a single shared shift-accumulator weights the result by bit position. In the cycle for the sign bit, the table output is subtracted instead of added.

The table contents are not fixed when the design is built. A load port shifts one table word into a chain of table entries on each cycle that the load enable is high. Software can therefore change the coefficients at run time: it computes every subset sum and streams the words in. The sample input uses a valid/ready handshake, and so does the result output. The rules are as follows:
- A sample is taken on any cycle in which `in_valid` and `in_ready` are both high.
- `in_ready` drops while a result is being computed, while a result waits for acceptance, and while a load is in progress.
- `in_valid` may be held high across those cycles without effect.
- A result is taken on any cycle in which `out_valid` and `out_ready` are both high.
- Until that happens, the result is held unchanged.

Top module: `da_fir_reload`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 while `load_en` is 0, all tap registers hold zero, and all table entries hold zero.
- R2: The result for the n-th accepted sample is the sum over k=0..7 of c[k]·x[n−k]. Tap 0 holds the newest sample. The result is a full-precision 19-bit two's-complement value, and both samples and coefficients are 8-bit two's complement.
- R3: The most significant sample bit carries negative weight. With all coefficients and all samples at −128, the result is +131072. With all of them at +127, the result is +129032. Neither case overflows.
- R4: `out_valid` rises exactly 8 clock edges after the edge that accepts a sample, provided `load_en` stays low during that time.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged. `in_ready` is low from the accepting edge until the result is taken.
- R6: A sample offered while `in_ready` is low is ignored: it does not enter the tap delay line and does not produce a result.
- R7: Each cycle with `load_en` high shifts every entry down by one position in a single chain, and `load_word` enters the top of the chain. After 32 loads, the first word written sits in table 0 at entry 0 and the last word sits in table 1 at entry 15. Table t is addressed with bit j taken from tap 4t+j. A table word is the sum of the coefficients whose address bits are 1, written as 10-bit two's complement.
- R8: While `load_en` is high, `in_ready` is low, incoming samples are ignored, and a pending result keeps both `out_valid` and its value. A computation in progress pauses.
- R9: Reloading the tables leaves the tap delay line untouched. The next result combines the new coefficients with the samples accepted earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter can accept a sample |
| in_sample | input | 8 | Two's-complement input sample |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 19 | Two's-complement filter output |
| load_en | input | 1 | Shift one table word into the chain |
| load_word | input | 10 | Table word to shift in |

## Verification
The bench goes after three corner cases.
- **Sign weighting at the extremes.** If the sign-bit cycle were added rather than subtracted, the all −128 and all +127 cases would produce results with the wrong sign or wrong magnitude. Too narrow an accumulator would wrap at the same cases.
- **Load order and tap order.** Asymmetric coefficients are used, so a chain that shifts the wrong way or an address bit that picks the wrong tap would give wrong values. These show up in impulse responses and in long pseudo-random streams.
- **Handshake edges and reload.** The bench offers samples while the filter is busy, holding a result, or loading, and checks that none of them reach the delay line. It stalls the output and reloads during the stall, and checks that the held result does not move. It also checks that the history survives a reload, so a design that cleared the taps or let stale tables leak would fail.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } fir_state_e;
endpackage

// File: rtl/da_fir_tables.sv
module da_fir_tables #(
  parameter int NTAB = 2,
  parameter int TPT  = 4,
  parameter int EW   = 10,
  localparam int DEPTH = 1 << TPT,
  localparam int TOTAL = NTAB * DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic [EW-1:0]        shift_in,
  input  logic [NTAB*TPT-1:0]  addr,
  output logic [NTAB*EW-1:0]   rd_data
);
  logic [EW-1:0] mem [TOTAL];

  // one chain across all tables: entry 0 of table 0 is the bottom
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < TOTAL - 1; i++) mem[i] <= mem[i+1];
      mem[TOTAL-1] <= shift_in;
    end
  end

  for (genvar t = 0; t < NTAB; t++) begin : g_rd
    assign rd_data[t*EW +: EW] = mem[t*DEPTH + int'(addr[t*TPT +: TPT])];
  end
endmodule

// File: rtl/da_fir_tapline.sv
module da_fir_tapline #(
  parameter int NTAPS = 8,
  parameter int SW    = 8,
  localparam int BIT_W = (SW > 1) ? $clog2(SW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SW-1:0]    sample,
  input  logic [BIT_W-1:0] bsel,
  output logic [NTAPS-1:0] slice
);
  logic [SW-1:0] taps [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
    end else if (push) begin
      taps[0] <= sample;
      for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
    end
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_slice
    assign slice[i] = taps[i][bsel];
  end
endmodule

// File: rtl/da_fir_shacc.sv
module da_fir_shacc #(
  parameter int SUM_W = 11,
  parameter int SW    = 8,
  localparam int ACC_W = SUM_W + SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             sign_bit,
  input  logic [SUM_W-1:0] psum,
  output logic [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] ext, weighted, nxt;

  always_comb begin
    ext      = {{(ACC_W-SUM_W){psum[SUM_W-1]}}, psum};
    weighted = ext <<< (SW - 1);
    if (sign_bit) nxt = ($signed(acc) >>> 1) - weighted;
    else          nxt = ($signed(acc) >>> 1) + weighted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (step)  acc <= nxt;
  end
endmodule

// File: rtl/da_fir_reload.sv
module da_fir_reload #(
  parameter int SW    = 8,
  parameter int CW    = 8,
  parameter int NTAPS = 8,
  localparam int TPT   = 4,
  localparam int NTAB  = NTAPS / TPT,
  localparam int EW    = CW + 2,
  localparam int SUM_W = EW + ((NTAB > 1) ? $clog2(NTAB) : 0),
  localparam int ACC_W = SUM_W + SW,
  localparam int BIT_W = (SW > 1) ? $clog2(SW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SW-1:0]    in_sample,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_result,
  input  logic             load_en,
  input  logic [EW-1:0]    load_word
);
  import da_fir_pkg::*;

  fir_state_e          st;
  logic [BIT_W-1:0]    bcnt;
  logic                accept, step, last;
  logic [NTAPS-1:0]    slice;
  logic [NTAB*EW-1:0]  rd_data;
  logic [SUM_W-1:0]    psum;

  assign in_ready  = (st == ST_IDLE) && !load_en;
  assign accept    = in_valid && in_ready;
  assign step      = (st == ST_RUN) && !load_en;
  assign last      = (bcnt == BIT_W'(SW - 1));
  assign out_valid = (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      bcnt <= '0;
    end else if (accept) begin
      st   <= ST_RUN;
      bcnt <= '0;
    end else if (step) begin
      if (last) st <= ST_HOLD;
      else      bcnt <= bcnt + 1'b1;
    end else if (st == ST_HOLD && out_ready && !load_en) begin
      st <= ST_IDLE;
    end
  end

  da_fir_tapline #(.NTAPS(NTAPS), .SW(SW)) u_taps (
    .clk(clk), .rst_n(rst_n), .push(accept), .sample(in_sample),
    .bsel(bcnt), .slice(slice)
  );

  da_fir_tables #(.NTAB(NTAB), .TPT(TPT), .EW(EW)) u_tab (
    .clk(clk), .rst_n(rst_n), .shift_en(load_en), .shift_in(load_word),
    .addr(slice), .rd_data(rd_data)
  );

  // add the partial sums of all tables
  always_comb begin
    psum = '0;
    for (int t = 0; t < NTAB; t++)
      psum = psum + {{(SUM_W-EW){rd_data[t*EW+EW-1]}}, rd_data[t*EW +: EW]};
  end

  da_fir_shacc #(.SUM_W(SUM_W), .SW(SW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
    .sign_bit(last), .psum(psum), .acc(out_result)
  );
endmodule

// File: rtl/da_fir_reload_chk.sv
module da_fir_reload_chk #(
  parameter int SW    = 8,
  parameter int ACC_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_result,
  input logic             load_en
);
  logic [7:0] cyc;
  logic       armed;

  // cycles of progress since the last accepted sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      armed <= 1'b0;
    end else if (in_valid && in_ready) begin
      cyc   <= '0;
      armed <= 1'b1;
    end else if (out_valid) begin
      armed <= 1'b0;
    end else if (armed && !load_en) begin
      cyc <= cyc + 1'b1;
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (armed && cyc == 8'(SW)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  assert_no_start_in_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !in_ready);

  assert_load_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && out_valid) |=> (out_valid && $stable(out_result)));

  assert_ready_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

bind da_fir_reload da_fir_reload_chk #(.SW(SW), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .load_en(load_en)
);

// File: tb/tb_da_fir_reload.sv
module tb_da_fir_reload;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [18:0] out_result;
  logic        load_en = 1'b0;
  logic [9:0]  load_word = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int coef [8];
  int hist [8];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  da_fir_reload dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .load_en(load_en), .load_word(load_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model();
    int s = 0;
    for (int k = 0; k < 8; k++) s += coef[k] * hist[k];
    return s;
  endfunction

  // R7: shift all 32 subset sums, table 0 entry 0 first
  task automatic load_tables(input bit busy_check);
    int prev = $signed(out_result);
    bit was_valid = out_valid;
    for (int t = 0; t < 2; t++) begin
      for (int e = 0; e < 16; e++) begin
        int w = 0;
        for (int j = 0; j < 4; j++) if (e[j]) w += coef[4*t + j];
        @(negedge clk);
        load_en = 1'b1;
        load_word = 10'(w);
        if (busy_check) begin
          in_valid = 1'b1;
          in_sample = 8'd99;
          check(in_ready == 1'b0, "R8 in_ready during load", int'(in_ready), 0);
          check(out_valid == was_valid && $signed(out_result) == prev,
                "R8 result held during load", $signed(out_result), prev);
        end
      end
    end
    @(negedge clk);
    load_en = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic send(input int x, input string req);
    int n = 0;
    int exp;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_sample = 8'(x);
    @(posedge clk);
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = $signed(8'(x));
    exp = model();
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && n < 50) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check(n == 8, "R4 latency", n, 8);
    check($signed(out_result) == exp, req, $signed(out_result), exp);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    coef = '{3, -7, 12, 100, -128, 127, -1, 55};
    load_tables(1'b0);
    send(5, "R1 taps start at zero");
  endtask

  task automatic t_impulse();
    send(1, "R2 impulse");
    for (int i = 0; i < 8; i++) send(0, "R2 impulse tail");
    send(-1, "R2 negative impulse");
  endtask

  task automatic t_extremes();
    coef = '{-128, -128, -128, -128, -128, -128, -128, -128};
    load_tables(1'b0);
    for (int i = 0; i < 8; i++) send(-128, "R3 negative extreme");
    check($signed(out_result) == 131072, "R3 peak value", $signed(out_result), 131072);
    coef = '{127, 127, 127, 127, 127, 127, 127, 127};
    load_tables(1'b0);
    for (int i = 0; i < 8; i++) send(127, "R3 positive extreme");
  endtask

  task automatic t_pattern();
    coef = '{-50, 21, 0, 90, -3, 64, -99, 17};
    load_tables(1'b0);
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'($signed(lfsr[7:0])), "R2 pseudo-random stream");
    end
  endtask

  task automatic t_backpressure();
    int held;
    int exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 8'd77;
    @(posedge clk);
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = 77;
    exp = model();
    @(negedge clk);
    in_sample = 8'd33;          // stays offered while busy: R6
    while (!out_valid) @(negedge clk);
    held = $signed(out_result);
    check(held == exp, "R2 result before stall", held, exp);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && $signed(out_result) == held,
            "R5 held under back-pressure", $signed(out_result), held);
      check(in_ready == 1'b0, "R6 in_ready low while pending", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R5 result consumed", int'(out_valid), 0);
    send(-9, "R6 ignored sample absent from history");
  endtask

  task automatic t_reload_hold();
    int held;
    int exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 8'(-40);
    @(posedge clk);
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = -40;
    exp = model();
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    held = $signed(out_result);
    check(held == exp, "R2 result before reload", held, exp);
    coef = '{11, -22, 33, -44, 55, -66, 77, -88};
    load_tables(1'b1);
    check(out_valid == 1'b1 && $signed(out_result) == held,
          "R8 result kept after load", $signed(out_result), held);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    send(6, "R9 history kept across reload");
    send(-2, "R7 new coefficients in use");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) hist[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_impulse();
    t_extremes();
    t_pattern();
    t_backpressure();
    t_reload_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule